// File: doc/BRIEF.md
# Memory-Bus Byte Parity Unit

This unit adds byte parity to a 16-bit external memory data bus. Each byte lane has its own parity pin: the upper pin covers data bits 15:8 and the lower pin covers bits 7:0. When the bus controller drives write data, the unit drives the matching parity bits in the same cycle. When read data returns, the unit compares the received parity bits with parity computed from the received data. Any mismatch raises a one-cycle error pulse and sets a sticky error flag.

A 16-bit control register sets the behaviour. It chooses even or odd parity and which address areas are covered. It also has a test bit that forces both parity pins high on every data write, which lets software provoke errors on purpose.

The sticky flag is held by a three-state machine:
- **CLEAN**: the flag reads 0.
- **SET**: the flag reads 1 and the clear sequence has not started.
- **ARMED**: the flag reads 1 and software has seen it.

The transitions are:
- **RAISE**: any state goes to SET on a checked mismatch.
- **ARM**: SET goes to ARMED on a register read.
- **CLEAR**: ARMED goes to CLEAN on a register write with bit 15 at 0.
- **REARM**: ARMED goes back to SET when a new error arrives. This also covers an error in the same cycle as the clearing write.

Top module: `bpar_unit`

## Requirements
- R1: After reset, `reg_rdata` reads 0, both parity outputs are 0 and `par_err_pulse` is 0.
- R2: The control register works as follows:
  - A register write (`reg_sel` and `reg_wr`) loads the force bit (bit 14), the polarity bit (bit 13) and the mode field (bits 12:11).
  - Those bits read back unchanged.
  - Bits 10:0 always read 0, whatever was written.
  - Writing 1 to bit 15 never sets the error flag.
- R3: On a valid write to an enabled area with force at 0:
  - `par_out[1]` is the parity of `bus_data[15:8]` and `par_out[0]` is the parity of `bus_data[7:0]`.
  - With polarity 0 (even), the bit equals the XOR of the byte's bits.
  - With polarity 1 (odd), the bit is the inverse of that XOR.
  - The outputs change combinationally in the same cycle.
- R4: The mode field selects the enabled areas:
  - 00 enables no area.
  - 01 enables accesses with `bus_in_dram` set.
  - 10 enables accesses with `bus_in_dram` or `bus_in_area2` set.
  - 11 behaves as 00.
- R5: `par_out` is 00 in any cycle without a valid write. It is also 00 on a valid write outside the enabled areas while force is 0.
- R6: With force (bit 14) at 1, every valid write drives `par_out` to 11, whatever the data, area or mode.
- R7: A valid read in an enabled area where either received parity bit differs from the expected bit has these effects:
  - On the next clock edge, `par_err_pulse` goes high for exactly one cycle and bit 15 of `reg_rdata` becomes 1.
  - Reads with matching parity, reads outside enabled areas, and writes never raise it.
  - The force bit has no effect on checking.
- R8: Once set, the error flag stays 1 until the clear sequence completes. Writing 0 to bit 15 before a read has returned the flag as 1 leaves it set.
- R9: The clear sequence works as follows:
  - After a register read while the flag is 1, a later register write with bit 15 at 0 clears the flag on that edge.
  - Writes with bit 15 at 1 in between do not clear the flag and do not cancel the read.
  - A read made while the flag was 0 does not count towards the sequence.
- R10: A mismatch in the same cycle as the clearing write keeps the flag set. A fresh read of 1 is then needed before a write of 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Control register selected |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register contents: flag, force, polarity, mode, zeros |
| bus_valid | input | 1 | A bus data transfer occurs this cycle |
| bus_write | input | 1 | 1 = data output (write), 0 = data input (read) |
| bus_in_dram | input | 1 | Address decodes to the DRAM area |
| bus_in_area2 | input | 1 | Address decodes to area 2 |
| bus_data | input | 16 | Data on the bus |
| bus_par_in | input | 2 | Received parity, bit 1 upper byte, bit 0 lower byte |
| par_out | output | 2 | Driven parity, bit 1 upper byte, bit 0 lower byte |
| par_err_pulse | output | 1 | One-cycle pulse on a detected mismatch |

## Verification
The assertions check five things on every cycle:
- A detected mismatch always shows as both the pulse and the flag on the next cycle.
- The flag never falls except right after a write of 0 to bit 15.
- A set flag holds through any cycle without such a write.
- The parity outputs are 0 outside valid writes.
- Force drives 11 on every valid write.

Other behaviour can only be shown by the bench's sweeps, because each depends on a computed value or on an ordered series of events:
- The parity values for each byte pattern and polarity.
- Which area and mode combinations are enabled.
- The need for a read of 1 before the clear.
- The error-wins case against a same-cycle clearing write.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    localparam int REG_W     = 16;
    localparam int FLAG_BIT  = 15;
    localparam int FORCE_BIT = 14;
    localparam int ODD_BIT   = 13;
    localparam int MODE_HI   = 12;
    localparam int MODE_LO   = 11;

    typedef enum logic [1:0] {
        AREA_NONE    = 2'b00,
        AREA_DRAM    = 2'b01,
        AREA_DRAM_A2 = 2'b10,
        AREA_RSVD    = 2'b11
    } area_mode_e;

    typedef enum logic [1:0] {
        FLG_CLEAN = 2'b00,
        FLG_SET   = 2'b01,
        FLG_ARMED = 2'b10
    } flag_state_e;

    typedef struct packed {
        logic       force_hi;
        logic       odd;
        area_mode_e mode;
    } par_cfg_t;

endpackage

// File: rtl/bpar_byte_par.sv
module bpar_byte_par #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic         odd,
    output logic         p
);
    // Reduction XOR gives the even-parity bit; odd polarity inverts it.
    assign p = (^d) ^ odd;
endmodule

// File: rtl/bpar_cfg_reg.sv
module bpar_cfg_reg
    import bpar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output par_cfg_t         cfg
);
    // Bit 15 belongs to the flag machine; bits 10:0 hold nothing.
    logic unused_wbits;
    assign unused_wbits = ^{wdata[FLAG_BIT], wdata[MODE_LO-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.force_hi <= wdata[FORCE_BIT];
            cfg.odd      <= wdata[ODD_BIT];
            cfg.mode     <= area_mode_e'(wdata[MODE_HI:MODE_LO]);
        end
    end
endmodule

// File: rtl/bpar_datapath.sv
module bpar_datapath
    import bpar_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = DATA_W / BYTE_W
) (
    input  par_cfg_t          cfg,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_in_dram,
    input  logic              bus_in_area2,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [NB-1:0]     bus_par_in,
    output logic [NB-1:0]     par_out,
    output logic              chk_err
);
    logic          area_on;
    logic          drive_en;
    logic [NB-1:0] exp_par;

    // Area decode from the mode field; reserved code behaves as off.
    always_comb begin
        unique case (cfg.mode)
            AREA_DRAM:    area_on = bus_in_dram;
            AREA_DRAM_A2: area_on = bus_in_dram | bus_in_area2;
            AREA_NONE:    area_on = 1'b0;
            AREA_RSVD:    area_on = 1'b0;
        endcase
    end

    // One parity tree per byte lane.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        bpar_byte_par #(.W(BYTE_W)) u_bp (
            .d   (bus_data[b*BYTE_W +: BYTE_W]),
            .odd (cfg.odd),
            .p   (exp_par[b])
        );
    end

    assign drive_en = bus_valid & bus_write;

    always_comb begin
        if (!drive_en) begin
            par_out = '0;
        end else if (cfg.force_hi) begin
            par_out = '1;
        end else if (area_on) begin
            par_out = exp_par;
        end else begin
            par_out = '0;
        end
    end

    assign chk_err = bus_valid & ~bus_write & area_on & (bus_par_in != exp_par);
endmodule

// File: rtl/bpar_err_fsm.sv
module bpar_err_fsm
    import bpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_err,
    input  logic rd_ev,
    input  logic clr_wr,
    output logic flag,
    output logic err_pulse
);
    flag_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FLG_CLEAN;
            err_pulse <= 1'b0;
        end else begin
            state_q   <= state_d;
            err_pulse <= chk_err;
        end
    end

    // Next state: RAISE, ARM, CLEAR, REARM. A new error always wins.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAN: if (chk_err) state_d = FLG_SET;
            FLG_SET: begin
                if (chk_err)    state_d = FLG_SET;
                else if (rd_ev) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (chk_err)     state_d = FLG_SET;
                else if (clr_wr) state_d = FLG_CLEAN;
            end
            default: state_d = FLG_CLEAN;
        endcase
    end

    // Outputs.
    always_comb begin
        flag = (state_q != FLG_CLEAN);
    end
endmodule

// File: rtl/bpar_unit.sv
module bpar_unit
    import bpar_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_sel,
    input  logic                     reg_rd,
    input  logic                     reg_wr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic                     bus_in_dram,
    input  logic                     bus_in_area2,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic [DATA_W/BYTE_W-1:0] bus_par_in,
    output logic [DATA_W/BYTE_W-1:0] par_out,
    output logic                     par_err_pulse
);
    localparam int NBYTES = DATA_W / BYTE_W;

    par_cfg_t cfg;
    logic     chk_err;
    logic     flag;
    logic     rd_ev;
    logic     wr_ev;
    logic     clr_wr;

    assign rd_ev  = reg_sel & reg_rd;
    assign wr_ev  = reg_sel & reg_wr;
    assign clr_wr = wr_ev & ~reg_wdata[FLAG_BIT];

    bpar_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ev),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    bpar_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
        .cfg          (cfg),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_in_dram  (bus_in_dram),
        .bus_in_area2 (bus_in_area2),
        .bus_data     (bus_data),
        .bus_par_in   (bus_par_in),
        .par_out      (par_out),
        .chk_err      (chk_err)
    );

    bpar_err_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_err   (chk_err),
        .rd_ev     (rd_ev),
        .clr_wr    (clr_wr),
        .flag      (flag),
        .err_pulse (par_err_pulse)
    );

    always_comb begin
        reg_rdata                  = '0;
        reg_rdata[FLAG_BIT]        = flag;
        reg_rdata[FORCE_BIT]       = cfg.force_hi;
        reg_rdata[ODD_BIT]         = cfg.odd;
        reg_rdata[MODE_HI:MODE_LO] = cfg.mode;
    end
endmodule

// File: rtl/bpar_unit_chk.sv
module bpar_unit_chk #(
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_sel,
    input logic          reg_wr,
    input logic [15:0]   reg_wdata,
    input logic [15:0]   reg_rdata,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [NB-1:0] par_out,
    input logic          par_err_pulse,
    input logic          chk_err
);
    a_r7_err_reported: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |=> (par_err_pulse && reg_rdata[15]));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15] && !(reg_sel && reg_wr && !reg_wdata[15])) |=> reg_rdata[15]);

    a_r9_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[15]) |-> $past(reg_sel && reg_wr && !reg_wdata[15]));

    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |-> (par_out == '0));

    a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && reg_rdata[14]) |-> (par_out == '1));
endmodule

bind bpar_unit bpar_unit_chk #(.NB(NBYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .par_out       (par_out),
    .par_err_pulse (par_err_pulse),
    .chk_err       (chk_err)
);

// File: tb/bpar_unit_tb_top.sv
module bpar_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic        bus_in_dram = 1'b0, bus_in_area2 = 1'b0;
    logic [15:0] bus_data = '0;
    logic [1:0]  bus_par_in = '0;
    logic [1:0]  par_out;
    logic        par_err_pulse;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpar_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_in_dram(bus_in_dram), .bus_in_area2(bus_in_area2),
        .bus_data(bus_data), .bus_par_in(bus_par_in), .par_out(par_out),
        .par_err_pulse(par_err_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] model_par(input logic [15:0] d, input logic odd);
        return {(^d[15:8]) ^ odd, (^d[7:0]) ^ odd};
    endfunction

    function automatic bit model_on(input logic [1:0] mode, input logic dr, input logic a2);
        case (mode)
            2'b01:   return dr;
            2'b10:   return dr | a2;
            default: return 1'b0;
        endcase
    endfunction

    task automatic reg_write(input logic [15:0] w);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(output logic [15:0] r);
        @(negedge clk);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #1 r = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    // One bus transfer; returns parity seen during it, pulse and flag after it,
    // and the pulse one cycle later.
    task automatic bus_op(input logic wr, input logic dr, input logic a2,
                          input logic [15:0] d, input logic [1:0] pin,
                          output logic [1:0] po, output logic pulse,
                          output logic flg, output logic pulse2);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_in_dram = dr; bus_in_area2 = a2;
        bus_data = d; bus_par_in = pin;
        #1 po = par_out;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_in_dram = 1'b0; bus_in_area2 = 1'b0;
        #1 pulse = par_err_pulse; flg = reg_rdata[15];
        @(negedge clk);
        #1 pulse2 = par_err_pulse;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r, cfg_w, d;
        logic [1:0]  po, ep;
        logic        pulse, flg, pulse2, on, e;

        repeat (3) @(negedge clk);
        #1;
        check(reg_rdata == 16'h0, "R1", "reset reg_rdata", reg_rdata, 0);
        check(par_out == 2'b00, "R1", "reset par_out", par_out, 0);
        check(par_err_pulse == 1'b0, "R1", "reset pulse", par_err_pulse, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: writing 1 to bit 15 never sets the flag; reserved bits read 0.
        reg_write(16'hFFFF);
        reg_read(r);
        check(r == 16'h7800, "R2", "write all ones readback", r, 16'h7800);

        // Near-exhaustive sweep: mode x polarity x force x area x data x parity-in.
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
                for (int f = 0; f < 2; f++) begin
                    cfg_w = {1'b0, f[0], o[0], m[1:0], 11'h7FF};
                    reg_write(cfg_w);
                    reg_read(r);
                    check(r == {1'b0, f[0], o[0], m[1:0], 11'h0}, "R2", "config readback",
                          r, {1'b0, f[0], o[0], m[1:0], 11'h0});
                    for (int a = 0; a < 4; a++) begin
                        on = model_on(m[1:0], a[0], a[1]);
                        for (int i = 0; i < 6; i++) begin
                            d = 16'(i * 16'h1357) ^ 16'(i << 12) ^ ((i == 5) ? 16'hFFFF : 16'h0);
                            ep = model_par(d, o[0]);
                            // Write direction.
                            bus_op(1'b1, a[0], a[1], d, 2'b00, po, pulse, flg, pulse2);
                            if (f != 0)
                                check(po == 2'b11, "R6", "forced parity", po, 2'b11);
                            else if (on)
                                check(po == ep, "R3", "generated parity", po, ep);
                            else
                                check(po == 2'b00, "R4", "disabled area parity", po, 2'b00);
                            check(pulse == 1'b0, "R7", "no error on write", pulse, 0);
                            // Read direction with every received parity value.
                            for (int p = 0; p < 4; p++) begin
                                e = on && (p[1:0] != ep);
                                bus_op(1'b0, a[0], a[1], d, p[1:0], po, pulse, flg, pulse2);
                                check(po == 2'b00, "R5", "parity low on read", po, 0);
                                check(pulse == e, "R7", "error pulse", pulse, e);
                                check(flg == e, "R7", "flag after read", flg, e);
                                check(pulse2 == 1'b0, "R7", "pulse one cycle", pulse2, 0);
                                if (e) begin
                                    reg_write(cfg_w);
                                    reg_read(r);
                                    check(r[15] == 1'b1, "R8", "flag kept without read", r[15], 1);
                                    reg_write(cfg_w);
                                    reg_read(r);
                                    check(r[15] == 1'b0, "R9", "flag cleared", r[15], 0);
                                end
                            end
                        end
                    end
                end
            end
        end

        // R5: no valid transfer at all.
        @(negedge clk); bus_write = 1'b1; bus_data = 16'h0001; #1;
        check(par_out == 2'b00, "R5", "write without valid", par_out, 0);
        bus_write = 1'b0;

        // R9: read while clean does not arm; write 1 keeps the armed read.
        cfg_w = 16'h0800;
        reg_write(cfg_w);
        reg_read(r);
        bus_op(1'b0, 1'b1, 1'b0, 16'h0000, 2'b11, po, pulse, flg, pulse2);
        check(flg == 1'b1, "R7", "mismatch sets flag", flg, 1);
        reg_write(cfg_w);
        reg_read(r);
        check(r[15] == 1'b1, "R9", "stale clean read ignored", r[15], 1);
        reg_write(cfg_w | 16'h8000);
        reg_read(r);
        check(r[15] == 1'b1, "R9", "write of 1 keeps flag", r[15], 1);
        reg_write(cfg_w);
        reg_read(r);
        check(r[15] == 1'b0, "R9", "clear after read and write 0", r[15], 0);

        // R10: error coincident with clearing write wins.
        bus_op(1'b0, 1'b1, 1'b0, 16'h0000, 2'b10, po, pulse, flg, pulse2);
        reg_read(r);
        check(r[15] == 1'b1, "R10", "flag before race", r[15], 1);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = cfg_w;
        bus_valid = 1'b1; bus_write = 1'b0; bus_in_dram = 1'b1;
        bus_data = 16'h0000; bus_par_in = 2'b01;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; bus_valid = 1'b0; bus_in_dram = 1'b0;
        #1;
        check(reg_rdata[15] == 1'b1, "R10", "error wins over clear", reg_rdata[15], 1);
        reg_write(cfg_w);
        #1;
        check(reg_rdata[15] == 1'b1, "R10", "fresh read required", reg_rdata[15], 1);
        reg_read(r);
        reg_write(cfg_w);
        #1;
        check(reg_rdata[15] == 1'b0, "R10", "cleared after fresh read", reg_rdata[15], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule